// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A register-mapped controller for one bank of general-purpose pins (32 by default). Software reads the synchronized pin levels, drives an output value and an output-enable (direction) per pin, and selects per pin whether a rising edge, a falling edge or both are captured. Captured edges sit in a sticky status register that software clears by writing ones. A mask register picks which status bits raise the single level-sensitive interrupt line.

The output value, the direction and the two edge-enable registers can each be changed one bit at a time, with no read-modify-write. Each has a write-only set alias and a write-only clear alias, and only the 1 bits of the written word take effect. The register bus is a plain single-cycle port: byte address, write strobe, write data, and read data that follows the address combinationally.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (pin_oe_o = 0), pin_o = 0, irq_o = 0, and the direction, both edge enables, the status and the mask all read 0.
- R2: Registers sit at byte addresses given by word index addr_i[5:2] with addr_i[1:0] = 0: 0 level (read), 1 direction (R/W), 2 output set (W), 3 output clear (W), 4 rising enable (R/W), 5 falling enable (R/W), 6 status (R/W1C), 7 direction set, 8 direction clear, 9 rising set, 10 rising clear, 11 falling set, 12 falling clear, 13 mask (R/W). An access with addr_i[1:0] != 0 is ignored, and an unused index reads 0.
- R3: The level register returns the pin inputs after a two-flop synchronizer: a change applied before clock edge k is readable after edge k+1 but not after edge k. Direction has no effect on it.
- R4: Writing to a set alias sets every target bit written as 1. Writing to a clear alias clears every target bit written as 1. Bits written as 0 keep their value. Targets: output value (pin_o), direction (pin_oe_o, 1 = output), rising enable and falling enable. An all-ones clear write empties the target.
- R5: A direct write to the direction, either edge enable or the mask replaces the whole register, and the register reads back what was written.
- R6: A rising edge on a pin sets its status bit only if its rising enable is 1, and a falling edge only if its falling enable is 1. With both enabled, either edge sets the bit. A pin change before clock edge k shows in status after edge k+2.
- R7: Writing the status register clears each bit written as 1. Bits written as 0 are unchanged.
- R8: irq_o is high while any status bit has its mask bit at 1 (1 = enabled), and it stays high until those bits are cleared.
- R9: If an enabled edge is detected in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R10: The write-only aliases (indices 2, 3, 7 to 12) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (6) | Byte address of the register |
| we_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | N (32) | Write data |
| rdata_o | output | N (32) | Read data for addr_i, combinational |
| pin_i | input | N (32) | Pin inputs, asynchronous |
| pin_o | output | N (32) | Output value per pin |
| pin_oe_o | output | N (32) | Output enable per pin, 1 = drive |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted output or direction bit shows on pin_o or pin_oe_o in the cycle after the write that caused it. A wrong enable or a lost status bit shows on read data and on irq_o two clock edges after the pin edge it should have caught. A clear that beats a simultaneous edge hides the fault until the next status read, one cycle later, so the bench aligns a falling edge exactly with a clear write to expose it. An address decode slip appears at once on a read, or as a wrong bit on the pin outputs one cycle after the write.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [3:0] {
    IDX_LEVEL    = 4'd0,
    IDX_DIR      = 4'd1,
    IDX_OUT_SET  = 4'd2,
    IDX_OUT_CLR  = 4'd3,
    IDX_RISE     = 4'd4,
    IDX_FALL     = 4'd5,
    IDX_STAT     = 4'd6,
    IDX_DIR_SET  = 4'd7,
    IDX_DIR_CLR  = 4'd8,
    IDX_RISE_SET = 4'd9,
    IDX_RISE_CLR = 4'd10,
    IDX_FALL_SET = 4'd11,
    IDX_FALL_CLR = 4'd12,
    IDX_MASK     = 4'd13
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end
  assign q_o = sync_q;
endmodule

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (wr_i)  q <= d_i;
    else if (set_i) q <= q | d_i;
    else if (clr_i) q <= q & ~d_i;
  end
  assign q_o = q;
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic         w1c_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, status_q, hit, clr;
  assign hit = (sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i);
  assign clr = w1c_i ? d_i : '0;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= sync_i;
      status_q <= (status_q & ~clr) | hit; // new edge beats clear
    end
  end
  assign status_o = status_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int N      = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe_o,
  output logic              irq_o
);
  import gpio_edge_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned, wr;
  logic [N-1:0]     level, dir_q, out_q, rise_q, fall_q, mask_q, status_q;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = we_i && aligned;

  function automatic logic hit(input logic [IDX_W-1:0] i, input reg_idx_e r);
    return i == IDX_W'(r);
  endfunction

  gpio_sync #(.W(N)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(level)
  );

  gpio_sc_reg #(.W(N)) u_out (
    .clk_i, .rst_ni, .wr_i(1'b0),
    .set_i(wr && hit(idx, IDX_OUT_SET)), .clr_i(wr && hit(idx, IDX_OUT_CLR)),
    .d_i(wdata_i), .q_o(out_q)
  );

  gpio_sc_reg #(.W(N)) u_dir (
    .clk_i, .rst_ni, .wr_i(wr && hit(idx, IDX_DIR)),
    .set_i(wr && hit(idx, IDX_DIR_SET)), .clr_i(wr && hit(idx, IDX_DIR_CLR)),
    .d_i(wdata_i), .q_o(dir_q)
  );

  gpio_sc_reg #(.W(N)) u_rise (
    .clk_i, .rst_ni, .wr_i(wr && hit(idx, IDX_RISE)),
    .set_i(wr && hit(idx, IDX_RISE_SET)), .clr_i(wr && hit(idx, IDX_RISE_CLR)),
    .d_i(wdata_i), .q_o(rise_q)
  );

  gpio_sc_reg #(.W(N)) u_fall (
    .clk_i, .rst_ni, .wr_i(wr && hit(idx, IDX_FALL)),
    .set_i(wr && hit(idx, IDX_FALL_SET)), .clr_i(wr && hit(idx, IDX_FALL_CLR)),
    .d_i(wdata_i), .q_o(fall_q)
  );

  gpio_sc_reg #(.W(N)) u_mask (
    .clk_i, .rst_ni, .wr_i(wr && hit(idx, IDX_MASK)),
    .set_i(1'b0), .clr_i(1'b0),
    .d_i(wdata_i), .q_o(mask_q)
  );

  gpio_edge_status #(.W(N)) u_stat (
    .clk_i, .rst_ni, .sync_i(level), .rise_en_i(rise_q), .fall_en_i(fall_q),
    .w1c_i(wr && hit(idx, IDX_STAT)), .d_i(wdata_i), .status_o(status_q)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if      (hit(idx, IDX_LEVEL)) rdata_o = level;
      else if (hit(idx, IDX_DIR))   rdata_o = dir_q;
      else if (hit(idx, IDX_RISE))  rdata_o = rise_q;
      else if (hit(idx, IDX_FALL))  rdata_o = fall_q;
      else if (hit(idx, IDX_STAT))  rdata_o = status_q;
      else if (hit(idx, IDX_MASK))  rdata_o = mask_q;
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int N      = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [N-1:0]      wdata_i,
  input logic [N-1:0]      rdata_o,
  input logic [N-1:0]      pin_o,
  input logic [N-1:0]      pin_oe_o,
  input logic              irq_o,
  input logic [N-1:0]      status_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      rise_q,
  input logic [N-1:0]      fall_q
);
  import gpio_edge_pkg::*;
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_OUT_SET = {IDX_W'(IDX_OUT_SET), 2'b00};
  localparam logic [ADDR_W-1:0] A_OUT_CLR = {IDX_W'(IDX_OUT_CLR), 2'b00};
  localparam logic [ADDR_W-1:0] A_DIR_SET = {IDX_W'(IDX_DIR_SET), 2'b00};

  a_r4_out_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT_CLR) |=> ((pin_o & $past(wdata_i)) == '0));

  a_r4_dir_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIR_SET) |=> ((pin_oe_o & $past(wdata_i)) == $past(wdata_i)));

  a_r6_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_q | fall_q)) == '0));

  a_r8_mask_gates_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  a_r10_alias_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_OUT_SET) |-> (rdata_o == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.N(N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o),
  .status_q(status_q), .mask_q(mask_q), .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/1ps
module tb_gpio_edge_bank;
  localparam int N = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_LEVEL = 6'h00, A_DIR = 6'h04, A_OSET = 6'h08, A_OCLR = 6'h0C,
    A_RISE = 6'h10, A_FALL = 6'h14, A_STAT = 6'h18, A_DSET = 6'h1C, A_DCLR = 6'h20,
    A_RSET = 6'h24, A_RCLR = 6'h28, A_FSET = 6'h2C, A_FCLR = 6'h30, A_MASK = 6'h34;

  logic clk = 0, rst_n = 0, we = 0, irq;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] wdata = '0, rdata, pin = '0, pout, poe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  gpio_edge_bank #(.N(N), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0; addr = A_LEVEL;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle_pins(input logic [N-1:0] v);
    @(negedge clk); pin = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    chk("R1 pin_o", pout, '0);
    chk("R1 pin_oe_o", poe, '0);
    chk("R1 irq_o", {31'd0, irq}, '0);
    rd(A_DIR, d);  chk("R1 dir", d, '0);
    rd(A_RISE, d); chk("R1 rise", d, '0);
    rd(A_FALL, d); chk("R1 fall", d, '0);
    rd(A_STAT, d); chk("R1 status", d, '0);
    rd(A_MASK, d); chk("R1 mask", d, '0);
  endtask

  task automatic t_level();
    @(negedge clk); pin = 32'hA5A5_0F0F;
    @(negedge clk); addr = A_LEVEL; #1 chk("R3 level one edge", rdata, '0);
    @(negedge clk); #1 chk("R3 level two edges", rdata, 32'hA5A5_0F0F);
  endtask

  task automatic t_aliases();
    logic [N-1:0] d;
    wr(A_OSET, 32'h0000_00FF); chk("R4 out set", pout, 32'h0000_00FF);
    wr(A_OSET, 32'hF000_0000); chk("R4 out set keeps", pout, 32'hF000_00FF);
    wr(A_OCLR, 32'h0000_000F); chk("R4 out clear", pout, 32'hF000_00F0);
    rd(A_OSET, d); chk("R10 out set reads 0", d, '0);
    rd(A_DCLR, d); chk("R10 dir clr reads 0", d, '0);
    wr(A_DIR, 32'h0000_FFFF); rd(A_DIR, d); chk("R5 dir write", d, 32'h0000_FFFF);
    wr(A_DSET, 32'hFF00_0000); chk("R4 dir set", poe, 32'hFF00_FFFF);
    wr(A_DCLR, 32'h0000_000F); rd(A_DIR, d); chk("R4 dir clear", d, 32'hFF00_FFF0);
    rd(A_LEVEL, d); chk("R3 level with outputs", d, 32'hA5A5_0F0F);
    wr(A_RSET, 32'h3); wr(A_RCLR, 32'h1); rd(A_RISE, d); chk("R4 rise set/clr", d, 32'h2);
    wr(A_FALL, 32'h5); wr(A_FSET, 32'h8); rd(A_FALL, d); chk("R4 fall set", d, 32'hD);
    wr(A_FCLR, '1); rd(A_FALL, d); chk("R4 fall clear all", d, '0);
    wr(A_RCLR, '1); rd(A_RISE, d); chk("R4 rise clear all", d, '0);
    wr(A_MASK, '1); rd(A_MASK, d); chk("R5 mask write", d, '1);
    wr(A_MASK, '0); rd(A_MASK, d); chk("R5 mask clear", d, '0);
    wr(A_DIR | 6'h1, 32'h1234_5678); rd(A_DIR, d); chk("R2 unaligned ignored", d, 32'hFF00_FFF0);
    rd(6'h38, d); chk("R2 unused index", d, '0);
    wr(A_OCLR, '1); chk("R4 out clear all", pout, '0);
  endtask

  task automatic t_edges();
    logic [N-1:0] d;
    settle_pins('0);
    wr(A_STAT, '1);
    wr(A_RISE, 32'h5); wr(A_FALL, 32'h6);
    settle_pins(32'hF);
    rd(A_STAT, d); chk("R6 rise only where enabled", d, 32'h5);
    chk("R8 masked off", {31'd0, irq}, '0);
    settle_pins('0);
    rd(A_STAT, d); chk("R6 fall adds", d, 32'h7);
    wr(A_MASK, 32'h8); chk("R8 mask bit without status", {31'd0, irq}, '0);
    wr(A_MASK, 32'h2); chk("R8 irq on", {31'd0, irq}, 32'h1);
    wr(A_STAT, 32'h5); rd(A_STAT, d); chk("R7 w1c", d, 32'h2);
    chk("R8 irq stays", {31'd0, irq}, 32'h1);
    wr(A_STAT, 32'h0); rd(A_STAT, d); chk("R7 zero write no effect", d, 32'h2);
    wr(A_STAT, 32'h2); chk("R8 irq drops", {31'd0, irq}, '0);
    wr(A_MASK, '0);
  endtask

  task automatic t_collision();
    logic [N-1:0] d;
    wr(A_RSET, 32'h10); wr(A_FSET, 32'h10);
    settle_pins(32'h10);
    rd(A_STAT, d); chk("R6 both enabled rise", d & 32'h10, 32'h10);
    @(negedge clk); pin = 32'h0;
    @(negedge clk);
    @(negedge clk); we = 1; addr = A_STAT; wdata = 32'h10;
    @(negedge clk); we = 0; wdata = '0;
    rd(A_STAT, d); chk("R9 edge beats clear", d & 32'h10, 32'h10);
    wr(A_STAT, 32'h10); rd(A_STAT, d); chk("R7 clear after collision", d, '0);
  endtask

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_level();
    t_aliases();
    t_edges();
    t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule